// File: doc/BRIEF.md
# Character Display Address and Shift Controller

This block keeps the cursor address and the horizontal view offset for an 80-character display buffer. A host issues one command per cycle on a strobe interface: write a character at the cursor, move the cursor, return home, shift the view left or right, or choose the line layout. The block has no storage for characters. It gives the current buffer write address with a write strobe, and for every visible row and column it gives the buffer address that the character generator must read.

The buffer can be laid out as one line of 80 positions, two lines of 40, or four lines of 20. Each layout places lines at fixed bases with gaps between them. The cursor steps over those gaps. When it runs off the end of a line it moves to the start of the next line, and after the last line it returns to the first. The view offset rotates each line onto itself. A character never moves from one line into another, and every line moves by the same amount.

Top module: `char_addr_ctrl`

## Requirements
- R1: After reset the cursor address is 0x00, the offset is 0, the one-line layout is active (`row_active` = 4'b0001) and `wr_en` is low.
- R2: The layout command (op 6) reads `cmd_arg[0]` as two-line and `cmd_arg[1]` as four-line. Four-line takes priority over `cmd_arg[0]`. `row_active` becomes 4'b1111, 4'b0011 or 4'b0001. The command also clears the cursor and the offset.
- R3: A write (op 1) raises `wr_en` in the same cycle, with `wr_addr` equal to the cursor. The cursor advances on the next clock edge.
- R4: Line bases are 0x00 for one line, 0x00/0x40 for two lines, and 0x00/0x20/0x40/0x60 for four lines. Line capacity is 80, 40 or 20. A write at the last column of a line moves the cursor to column 0 of the next line. A write at the last column of the last line moves it to 0x00.
- R5: Set-cursor (op 2) loads `cmd_arg` when its column is below the capacity of the active layout. The column is `cmd_arg`, `cmd_arg[5:0]` or `cmd_arg[4:0]` for one, two or four lines. Any other value leaves the cursor unchanged.
- R6: Shift-left (op 4) adds 1 to the offset and shift-right (op 5) subtracts 1, both modulo the line capacity. The cursor is not changed.
- R7: For an active row r and visible column c, the read address is base(r) + ((c + offset) mod capacity). Inactive rows read 0x00.
- R8: Return-home (op 3) sets both the cursor and the offset to 0.
- R9: A cycle with `cmd_valid` low, with op 0, or with op 7 changes neither the cursor nor the offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code |
| cmd_arg | input | 7 | Command argument (address or layout bits) |
| wr_en | output | 1 | Write strobe for the character buffer |
| wr_addr | output | 7 | Current cursor address |
| row_active | output | 4 | One bit per display row in use |
| rd_addr | output | 4*VIS_COLS*7 | Read address per row and column, index (row*VIS_COLS+col)*7 |

## Verification
In every layout the cursor is walked through a full cycle of writes plus one more. This separates a correct jump over the line gaps from an address that runs straight into a gap, and it shows the return from the last line. All 128 set-cursor arguments are applied in each layout, which splits accepted addresses from rejected ones at the exact capacity boundary. The offset is rotated past a full line in both directions while the whole read grid is compared. This catches an off-by-one in the wrap and any row that borrows characters from its neighbour. Idle, no-op and unused-code cycles are placed between these steps to show that they change nothing.

// File: rtl/char_addr_ctrl.sv
module char_addr_ctrl #(
  parameter int VIS_COLS = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cmd_valid,
  input  logic [2:0]                  cmd_op,
  input  logic [6:0]                  cmd_arg,
  output logic                        wr_en,
  output logic [6:0]                  wr_addr,
  output logic [3:0]                  row_active,
  output logic [4*VIS_COLS*7-1:0]     rd_addr
);
  localparam logic [2:0] OP_WRITE = 3'd1, OP_SET = 3'd2, OP_HOME = 3'd3,
                         OP_SHL = 3'd4, OP_SHR = 3'd5, OP_MODE = 3'd6;

  logic       two_ln, four_ln;
  logic [1:0] cur_line;
  logic [6:0] cur_col, off, cap;
  logic [1:0] last_line;

  function automatic logic [6:0] base_of(input logic fl, input logic tl, input logic [1:0] ln);
    if (fl)      return {ln, 5'd0};
    else if (tl) return {ln[0], 6'd0};
    else         return 7'd0;
  endfunction

  assign cap        = four_ln ? 7'd20 : two_ln ? 7'd40 : 7'd80;
  assign last_line  = four_ln ? 2'd3 : two_ln ? 2'd1 : 2'd0;
  assign row_active = four_ln ? 4'b1111 : two_ln ? 4'b0011 : 4'b0001;
  assign wr_en      = cmd_valid && cmd_op == OP_WRITE;
  assign wr_addr    = base_of(four_ln, two_ln, cur_line) + cur_col;

  logic [1:0] set_line;
  logic [6:0] set_col;
  always_comb begin
    if (four_ln) begin
      set_line = cmd_arg[6:5];
      set_col  = {2'd0, cmd_arg[4:0]};
    end else if (two_ln) begin
      set_line = {1'b0, cmd_arg[6]};
      set_col  = {1'b0, cmd_arg[5:0]};
    end else begin
      set_line = 2'd0;
      set_col  = cmd_arg;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      two_ln   <= 1'b0;
      four_ln  <= 1'b0;
      cur_line <= 2'd0;
      cur_col  <= 7'd0;
      off      <= 7'd0;
    end else if (cmd_valid) begin
      case (cmd_op)
        OP_WRITE: begin
          if (cur_col == cap - 7'd1) begin
            cur_col  <= 7'd0;
            cur_line <= (cur_line == last_line) ? 2'd0 : cur_line + 2'd1;
          end else begin
            cur_col <= cur_col + 7'd1;
          end
        end
        OP_SET: if (set_col < cap) begin
          cur_line <= set_line;
          cur_col  <= set_col;
        end
        OP_HOME: begin
          cur_line <= 2'd0;
          cur_col  <= 7'd0;
          off      <= 7'd0;
        end
        OP_SHL: off <= (off == cap - 7'd1) ? 7'd0 : off + 7'd1;
        OP_SHR: off <= (off == 7'd0) ? cap - 7'd1 : off - 7'd1;
        OP_MODE: begin
          two_ln   <= cmd_arg[0];
          four_ln  <= cmd_arg[1];
          cur_line <= 2'd0;
          cur_col  <= 7'd0;
          off      <= 7'd0;
        end
        default: ;
      endcase
    end
  end

  for (genvar r = 0; r < 4; r++) begin : g_row
    for (genvar c = 0; c < VIS_COLS; c++) begin : g_col
      logic [6:0] sum, wrapped;
      assign sum     = 7'(c) + off;
      assign wrapped = (sum >= cap) ? sum - cap : sum;
      assign rd_addr[(r*VIS_COLS+c)*7 +: 7] =
        (2'(r) <= last_line) ? base_of(four_ln, two_ln, 2'(r)) + wrapped : 7'd0;
    end
  end

  initial if (VIS_COLS < 1 || VIS_COLS > 20) $error("VIS_COLS must be 1..20");
endmodule

// File: rtl/char_addr_ctrl_chk.sv
module char_addr_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [2:0] cmd_op,
  input logic       wr_en,
  input logic [6:0] wr_addr,
  input logic [3:0] row_active,
  input logic [6:0] off,
  input logic [6:0] cap
);
  assert_layout_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    row_active == 4'b0001 || row_active == 4'b0011 || row_active == 4'b1111);

  assert_write_moves_cursor_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> wr_addr != $past(wr_addr));

  assert_offset_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    off < cap);

  assert_shift_keeps_cursor_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_op == 3'd4 || cmd_op == 3'd5) |=> $stable(wr_addr));

  assert_home_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 3'd3 |=> wr_addr == 7'd0 && off == 7'd0);

  assert_idle_no_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(wr_addr) && $stable(off));
endmodule

bind char_addr_ctrl char_addr_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .wr_en(wr_en), .wr_addr(wr_addr), .row_active(row_active),
  .off(off), .cap(cap)
);

// File: tb/tb_char_addr_ctrl.sv
`timescale 1ns/1ps
module tb_char_addr_ctrl;
  localparam int VC = 8;
  logic clk = 0, rst_n = 0, cmd_valid = 0;
  logic [2:0] cmd_op = 0;
  logic [6:0] cmd_arg = 0;
  logic wr_en;
  logic [6:0] wr_addr;
  logic [3:0] row_active;
  logic [4*VC*7-1:0] rd_addr;

  char_addr_ctrl #(.VIS_COLS(VC)) dut (.*);

  always #4 clk = ~clk;

  int vec = 0, bad = 0, cycles = 0;
  int m_lines = 1, m_line = 0, m_col = 0, m_off = 0;

  function automatic int mcap(int l); return 80 / l; endfunction
  function automatic int mbase(int l, int ln);
    return (l == 4) ? ln * 32 : (l == 2) ? ln * 64 : 0;
  endfunction
  function automatic int maddr(); return mbase(m_lines, m_line) + m_col; endfunction

  task automatic report_done();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      vec++; bad++;
      $display("FAIL watchdog: actual %0d cycles, expected < 150000", cycles);
      report_done();
    end
  end

  task automatic chk(string req, int act, int exp);
    vec++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_grid(string req);
    int errs = 0, fa = 0, fe = 0;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < VC; c++) begin
        int e = (r < m_lines) ? mbase(m_lines, r) + ((c + m_off) % mcap(m_lines)) : 0;
        int a = int'(rd_addr[(r*VC+c)*7 +: 7]);
        if (a != e) begin errs++; fa = a; fe = e; end
      end
    vec++;
    if (errs != 0) begin
      bad++;
      $display("FAIL %s: grid actual %0d expected %0d (%0d cells)", req, fa, fe, errs);
    end
  endtask

  task automatic m_apply(int op, int arg);
    int cp = mcap(m_lines), cl;
    case (op)
      1: if (m_col == cp - 1) begin m_col = 0; m_line = (m_line == m_lines - 1) ? 0 : m_line + 1; end
         else m_col++;
      2: begin
        cl = (m_lines == 1) ? arg : (m_lines == 2) ? arg % 64 : arg % 32;
        if (cl < cp) begin m_col = cl; m_line = (m_lines == 1) ? 0 : (m_lines == 2) ? arg / 64 : arg / 32; end
      end
      3: begin m_col = 0; m_line = 0; m_off = 0; end
      4: m_off = (m_off + 1) % cp;
      5: m_off = (m_off + cp - 1) % cp;
      6: begin m_lines = arg[1] ? 4 : arg[0] ? 2 : 1; m_col = 0; m_line = 0; m_off = 0; end
      default: ;
    endcase
  endtask

  task automatic issue(int op, int arg, bit valid = 1);
    @(negedge clk);
    cmd_valid = valid; cmd_op = 3'(op); cmd_arg = 7'(arg);
    #1;
    if (valid && op == 1) begin
      chk("R3 wr_en", int'(wr_en), 1);
      chk("R4 write address", int'(wr_addr), maddr());
    end
    @(posedge clk); #2;
    cmd_valid = 0;
    if (valid) m_apply(op, arg);
  endtask

  task automatic chk_state(string req);
    @(negedge clk);
    chk(req, int'(wr_addr), maddr());
    chk_grid(req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 cursor", int'(wr_addr), 0);
    chk("R1 rows", int'(row_active), 1);
    chk("R1 wr_en", int'(wr_en), 0);
    chk_grid("R1 grid");

    for (int md = 0; md < 4; md++) begin
      issue(6, md);
      @(negedge clk);
      chk("R2 rows", int'(row_active), m_lines == 4 ? 15 : m_lines == 2 ? 3 : 1);
      chk_state("R2 cleared");
      for (int i = 0; i <= 80; i++) issue(1, 0);
      chk_state("R4 after full cycle");
      for (int a = 0; a < 128; a++) begin
        issue(2, a);
        chk_state("R5 set cursor");
      end
      issue(2, 5 + mbase(m_lines, m_lines - 1));
      for (int i = 0; i < mcap(m_lines) + 2; i++) begin
        issue(4, 0);
        chk_state("R6 shift left");
        chk_grid("R7 read map");
      end
      for (int i = 0; i < mcap(m_lines) + 3; i++) begin
        issue(5, 0);
        chk_state("R6 shift right");
      end
      issue(4, 0);
      issue(0, 0, 0); issue(0, 0); issue(7, 99); issue(4, 0, 0);
      chk_state("R9 no effect");
      issue(3, 0);
      chk_state("R8 home");
      chk("R8 home zero", int'(wr_addr), 0);
    end
    report_done();
  end
endmodule